// File: doc/BRIEF.md
# Interrupt Route Dispatcher

This block sits between a bank of interrupt input lines and the message fabric that reaches the processors. Each line has a routing entry. An upstream agent presents one line event at a time. The block captures that line's entry and either discards the event, flags it, or turns it into one or more interrupt messages on a valid/ready port. Every message carries a destination ID, a vector, a delivery mode and a destination-mode flag.

Physical routing sends one message to the ID stored in the entry. Logical routing treats the 8-bit destination as a set of processors. The block then sends one message for each set bit, addressed to that bit's index, lowest index first. The routing table arrives as a flat input vector, so the block does not care how software fills it.

Each entry is 21 bits wide. From the top bit down, the fields are: destination [20:13], mask [12], destination mode [11], delivery mode [10:8], vector [7:0]. The control is a three-state machine:

- IDLE waits for an event.
- An accepted event moves IDLE→PHYS (physical routing) or IDLE→LOGI (logical routing, non-zero bitmap).
- Every other outcome of an event keeps IDLE→IDLE.
- PHYS→IDLE happens when its one message is accepted.
- LOGI→LOGI happens on each accepted message while set bits remain.
- LOGI→IDLE happens when the last set bit's message is accepted.

Top module: `irq_route_dispatch`

## Requirements
- R1: After reset, busy, err and msg_valid are all low.
- R2: An event on a line whose entry has mask bit [12] set produces no message and no error, whatever its delivery mode, and busy stays low.
- R3: An unmasked event whose delivery mode [10:8] is 3 or 6 produces no message and raises err for exactly the one cycle after the event is taken.
- R4: An event whose line number is at or above NUM_LINES produces no message and raises err for one cycle.
- R5: With destination mode [11] = 0, exactly one message is sent. Its msg_dest equals destination [20:13] and msg_destmode is 0.
- R6: With destination mode [11] = 1, one message is sent for each set bit i of destination [20:13], with msg_dest = i and msg_destmode = 1, in ascending order of i.
- R7: With destination mode 1 and an all-zero destination, no message is sent, no error is raised and busy stays low.
- R8: While msg_valid is high and msg_ready is low, msg_valid stays high and all message fields stay stable.
- R9: busy rises the cycle after an event that yields messages is taken, and falls right after the last of them is accepted. Events presented while busy are dropped.
- R10: Every message carries the vector [7:0] and delivery mode [10:8] of the entry that was captured when the event was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Line event present; taken when busy is low |
| evt_line | input | LINE_W | Line number of the event |
| route_table | input | NUM_LINES*21 | Routing entries, entry k in bits [21k+20:21k] |
| busy | output | 1 | Messages of an accepted event still pending |
| err | output | 1 | One-cycle pulse for a reserved mode or an out-of-range line |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver accepts the offered message |
| msg_dest | output | 8 | Destination ID |
| msg_vector | output | 8 | Interrupt vector |
| msg_dmode | output | 3 | Delivery mode |
| msg_destmode | output | 1 | 0 for physical, 1 for logical |

## Verification
The bench builds the block with NUM_LINES = 6. That gives a 3-bit line number, so lines 6 and 7 exist on the port but lie outside the table, and the out-of-range path can be reached directly. With six entries, every delivery-mode class fits in the table at once: a normal mode, both reserved codes, a masked entry and a zero bitmap. The tests rewrite entries between events to cover the bitmap extremes, a single top bit and a sparse pattern. They also stall the receiver to hold messages in place.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int DEST_W = 8;
    localparam int VEC_W  = 8;
    localparam int DM_W   = 3;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              destmode;
        logic [DM_W-1:0]   dmode;
        logic [VEC_W-1:0]  vector;
    } irq_entry_t;

    localparam int ENTRY_W = $bits(irq_entry_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PHYS = 2'd1,
        ST_LOGI = 2'd2
    } disp_state_t;

    function automatic logic dmode_reserved(input logic [DM_W-1:0] m);
        return (m == 3'd3) || (m == 3'd6);
    endfunction
endpackage

// File: rtl/irq_route_entry_pick.sv
module irq_route_entry_pick
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES = 24,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES*ENTRY_W-1:0] table_flat,
    input  logic [LINE_W-1:0]            line,
    output irq_entry_t                   entry,
    output logic                         in_range
);
    irq_entry_t slots [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_unpack
        assign slots[g] = table_flat[g*ENTRY_W +: ENTRY_W];
    end

    assign in_range = ({1'b0, line} < (LINE_W+1)'(NUM_LINES));

    always_comb begin
        entry = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (line == LINE_W'(i)) entry = slots[i];
        end
    end
endmodule

// File: rtl/irq_route_lowbit.sv
module irq_route_lowbit #(
    parameter int WIDTH = 8,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_route_dispatch.sv
module irq_route_dispatch
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES = 24,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         evt_valid,
    input  logic [LINE_W-1:0]            evt_line,
    input  logic [NUM_LINES*ENTRY_W-1:0] route_table,
    output logic                         busy,
    output logic                         err,
    output logic                         msg_valid,
    input  logic                         msg_ready,
    output logic [DEST_W-1:0]            msg_dest,
    output logic [VEC_W-1:0]             msg_vector,
    output logic [DM_W-1:0]              msg_dmode,
    output logic                         msg_destmode
);
    localparam int IDX_W = $clog2(DEST_W);

    disp_state_t       state_q, state_d;
    logic [DEST_W-1:0] dest_q, dest_d;   // physical ID, or pending bitmap in LOGI
    logic [VEC_W-1:0]  vec_q, vec_d;
    logic [DM_W-1:0]   dm_q, dm_d;
    logic              dsm_q, dsm_d;
    logic              err_q, err_d;

    irq_entry_t        pick;
    logic              pick_ok;
    logic [IDX_W-1:0]  low_idx;

    irq_route_entry_pick #(.NUM_LINES(NUM_LINES)) u_pick (
        .table_flat (route_table),
        .line       (evt_line),
        .entry      (pick),
        .in_range   (pick_ok)
    );

    irq_route_lowbit #(.WIDTH(DEST_W)) u_low (
        .vec (dest_q),
        .idx (low_idx)
    );

    // next-state and capture
    always_comb begin
        state_d = state_q;
        dest_d  = dest_q;
        vec_d   = vec_q;
        dm_d    = dm_q;
        dsm_d   = dsm_q;
        err_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (evt_valid) begin
                    if (!pick_ok) begin
                        err_d = 1'b1;
                    end else if (pick.mask) begin
                        err_d = 1'b0;
                    end else if (dmode_reserved(pick.dmode)) begin
                        err_d = 1'b1;
                    end else if (!pick.destmode || (pick.dest != '0)) begin
                        dest_d  = pick.dest;
                        vec_d   = pick.vector;
                        dm_d    = pick.dmode;
                        dsm_d   = pick.destmode;
                        state_d = pick.destmode ? ST_LOGI : ST_PHYS;
                    end
                end
            end
            ST_PHYS: begin
                if (msg_ready) state_d = ST_IDLE;
            end
            ST_LOGI: begin
                if (msg_ready) begin
                    dest_d = dest_q & (dest_q - 1'b1);
                    if (dest_d == '0) state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dest_q  <= '0;
            vec_q   <= '0;
            dm_q    <= '0;
            dsm_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            dest_q  <= dest_d;
            vec_q   <= vec_d;
            dm_q    <= dm_d;
            dsm_q   <= dsm_d;
            err_q   <= err_d;
        end
    end

    // outputs
    always_comb begin
        busy         = (state_q != ST_IDLE);
        msg_valid    = (state_q != ST_IDLE);
        err          = err_q;
        msg_vector   = vec_q;
        msg_dmode    = dm_q;
        msg_destmode = dsm_q;
        msg_dest     = (state_q == ST_LOGI) ? DEST_W'(low_idx) : dest_q;
    end

    // R8: offered message held until taken
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_dest) &&
        $stable(msg_vector) && $stable(msg_dmode) && $stable(msg_destmode));

    // R6: logical IDs strictly ascend within an event
    assert_ascend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready && msg_destmode |=>
        !msg_valid || (msg_dest > $past(msg_dest)));

    // R5: physical routing ends after one accepted message
    assert_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready && !msg_destmode |=> !msg_valid);

    // R3: reserved delivery modes never leave the block
    assert_no_rsv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !dmode_reserved(msg_dmode));

    // R9: busy only drops after a handshake
    assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(msg_valid && msg_ready));

    // R4: error pulses never coincide with an event in flight
    assert_err_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
endmodule

// File: tb/irq_route_dispatch_tb_top.sv
module irq_route_dispatch_tb_top;
    import irq_route_pkg::*;

    localparam int NL = 6;
    localparam int LW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_valid = 1'b0;
    logic [LW-1:0] evt_line = '0;
    logic [NL*ENTRY_W-1:0] route_table;
    logic busy, err, msg_valid, msg_ready, msg_destmode;
    logic [7:0] msg_dest, msg_vector;
    logic [2:0] msg_dmode;

    irq_entry_t tbl [NL];
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NL; i++) route_table[i*ENTRY_W +: ENTRY_W] = tbl[i];
    end

    irq_route_dispatch #(.NUM_LINES(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_line(evt_line),
        .route_table(route_table), .busy(busy), .err(err),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
        .msg_vector(msg_vector), .msg_dmode(msg_dmode), .msg_destmode(msg_destmode)
    );

    function automatic irq_entry_t mk(input logic m, input logic [7:0] d,
                                      input logic dsm, input logic [2:0] dm,
                                      input logic [7:0] v);
        irq_entry_t e;
        e.mask = m; e.dest = d; e.destmode = dsm; e.dmode = dm; e.vector = v;
        return e;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fire(input logic [LW-1:0] line);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_line  = line;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic quiet(input string req, input logic exp_err);
        chk(req, {busy, msg_valid, err}, {2'b00, exp_err});
        @(negedge clk);
        chk(req, {busy, msg_valid, err}, 3'b000);
    endtask

    task automatic drain(input string req, input logic [7:0] ids [8], input int n,
                         input logic [7:0] vec, input logic [2:0] dm,
                         input logic dsm, input int stall);
        for (int k = 0; k < n; k++) begin
            for (int s = 0; s < stall; s++) begin
                chk({req, " R8 held"}, {busy, msg_valid}, 2'b11);
                chk({req, " R8 dest"}, msg_dest, ids[k]);
                @(negedge clk);
            end
            chk({req, " R9 busy"}, {busy, msg_valid}, 2'b11);
            chk({req, " dest"}, msg_dest, ids[k]);
            chk({req, " R10 vec"}, msg_vector, vec);
            chk({req, " R10 dmode"}, msg_dmode, dm);
            chk({req, " destmode"}, msg_destmode, dsm);
            msg_ready = 1'b1;
            @(negedge clk);
            msg_ready = 1'b0;
        end
        chk({req, " R9 end"}, {busy, msg_valid}, 2'b00);
    endtask

    task automatic t_reset();
        chk("R1 reset", {busy, msg_valid, err}, 3'b000);
    endtask

    task automatic t_masked();
        fire(3'd2);
        quiet("R2 masked", 1'b0);
        tbl[3] = mk(1'b1, 8'h01, 1'b0, 3'd3, 8'h10);
        fire(3'd3);
        quiet("R2 masked reserved", 1'b0);
    endtask

    task automatic t_reserved();
        tbl[3] = mk(1'b0, 8'h01, 1'b0, 3'd3, 8'h10);
        fire(3'd3);
        quiet("R3 mode3", 1'b1);
        fire(3'd4);
        quiet("R3 mode6", 1'b1);
    endtask

    task automatic t_range();
        fire(3'd6);
        quiet("R4 line6", 1'b1);
        fire(3'd7);
        quiet("R4 line7", 1'b1);
    endtask

    task automatic t_physical();
        fire(3'd0);
        drain("R5 phys", '{8'h3C, 0, 0, 0, 0, 0, 0, 0}, 1, 8'h41, 3'd0, 1'b0, 3);
        tbl[5] = mk(1'b0, 8'hFF, 1'b0, 3'd7, 8'h99);
        fire(3'd5);
        drain("R5 phys ff", '{8'hFF, 0, 0, 0, 0, 0, 0, 0}, 1, 8'h99, 3'd7, 1'b0, 0);
    endtask

    task automatic t_logical();
        fire(3'd1);
        drain("R6 map a5", '{8'd0, 8'd2, 8'd5, 8'd7, 0, 0, 0, 0}, 4, 8'h52, 3'd1, 1'b1, 2);
        tbl[1] = mk(1'b0, 8'h80, 1'b1, 3'd4, 8'h23);
        fire(3'd1);
        drain("R6 map 80", '{8'd7, 0, 0, 0, 0, 0, 0, 0}, 1, 8'h23, 3'd4, 1'b1, 0);
        tbl[1] = mk(1'b0, 8'hFF, 1'b1, 3'd2, 8'h77);
        fire(3'd1);
        drain("R6 map ff", '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7}, 8,
              8'h77, 3'd2, 1'b1, 0);
    endtask

    task automatic t_zero();
        tbl[5] = mk(1'b0, 8'h00, 1'b1, 3'd5, 8'h31);
        fire(3'd5);
        quiet("R7 zero map", 1'b0);
    endtask

    task automatic t_busy();
        tbl[1] = mk(1'b0, 8'h06, 1'b1, 3'd0, 8'h64);
        fire(3'd1);
        chk("R9 busy rise", busy, 1'b1);
        fire(3'd0);
        fire(3'd6);
        chk("R9 no err while busy", err, 1'b0);
        drain("R9 busy drop", '{8'd1, 8'd2, 0, 0, 0, 0, 0, 0}, 2, 8'h64, 3'd0, 1'b1, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 dropped event", {busy, msg_valid, err}, 3'b000);
        end
    endtask

    initial begin
        msg_ready = 1'b0;
        tbl[0] = mk(1'b0, 8'h3C, 1'b0, 3'd0, 8'h41);
        tbl[1] = mk(1'b0, 8'hA5, 1'b1, 3'd1, 8'h52);
        tbl[2] = mk(1'b1, 8'h02, 1'b0, 3'd4, 8'h60);
        tbl[3] = mk(1'b0, 8'h01, 1'b0, 3'd3, 8'h10);
        tbl[4] = mk(1'b0, 8'h01, 1'b1, 3'd6, 8'h11);
        tbl[5] = mk(1'b0, 8'h00, 1'b1, 3'd5, 8'h31);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked();
        t_reserved();
        t_range();
        t_physical();
        t_logical();
        t_zero();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=%0d expected=20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule